// File: doc/BRIEF.md
# Static Memory Timing Sequencer

This block turns single-word read and write requests into the chip-select, output-enable and write-enable strobe sequence needed by an external asynchronous flash or SRAM device. Each phase of an access is timed by a wait-state count in bus-clock cycles. The count is taken from static configuration inputs, and each strobe edge follows its own offset rule. A request port accepts an address, write data and a direction under a valid/ready handshake. Each access ends with a one-cycle done pulse, which carries the read data for reads.

The data bus can be set to 8 or 16 bits wide. After every access the block holds chip-select high for a programmable turnaround gap before it starts the next access. It keeps its ready output low for the whole gap, so that a waiting request is held off and starts at the earliest allowed cycle.

Top module: `static_mem_seq`

## Requirements
- R1: Out of reset and while idle, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high (all strobes are active low), `req_ready` is high and `rsp_done` is low.
- R2: In a read, `mem_oe_n` falls `cfg_oe_dly` cycles after `mem_cs_n` falls. A value of 0 means the same cycle. If the delay is longer than the read cycle, `mem_oe_n` never falls.
- R3: A read holds `mem_cs_n` low for `cfg_rd_len`+1 cycles. `mem_oe_n` rises in the same cycle as `mem_cs_n`. The read data is sampled from `mem_dq_in` in the last low cycle.
- R4: In a write, `mem_we_n` falls `cfg_we_dly`+1 cycles after `mem_cs_n` falls.
- R5: A write holds `mem_cs_n` low for `cfg_wr_len`+2 cycles. `mem_we_n` rises in the same cycle as `mem_cs_n`. `mem_dq_oe` is high and the write data is on `mem_dq_out` for every cycle of the write.
- R6: If `cfg_we_dly`+1 is not less than `cfg_wr_len`+2, `mem_we_n` is still low for exactly one cycle, the last cycle of the write.
- R7: After an access, `mem_cs_n` stays high for at least `cfg_turn`+1 cycles. `req_ready` is low for the first `cfg_turn` of those cycles. A request that is waiting starts after exactly `cfg_turn`+1 high cycles.
- R8: A `cfg_turn` value of 15 acts as 14, which gives a 15-cycle gap.
- R9: `cfg_width` 2'b00 selects an 8-bit bus. A read returns `mem_dq_in[7:0]` zero-extended. A write drives `req_wdata[7:0]` on `mem_dq_out[7:0]` and zeros on bits 15:8. Codes 2'b01, 2'b10 and 2'b11 all select the 16-bit bus.
- R10: `rsp_done` is high for exactly one cycle per access: the first cycle in which `mem_cs_n` is high again. For reads, `rsp_rdata` holds the captured word in that cycle.
- R11: `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_dly | input | 4 | Chip-select to write-enable fall delay, n+1 cycles |
| cfg_oe_dly | input | 4 | Chip-select to output-enable fall delay, n cycles |
| cfg_rd_len | input | 5 | Read cycle length, n+1 cycles |
| cfg_wr_len | input | 5 | Chip-select fall to write-enable rise, n+2 cycles |
| cfg_turn | input | 4 | Turnaround gap, n+1 cycles (15 acts as 14) |
| cfg_width | input | 2 | Bus width: 00 is 8-bit, any other code is 16-bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Device address |
| mem_dq_out | output | 16 | Data driven toward the device |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned by the device |

## Verification
A wrong phase counter changes when a strobe edge falls relative to the fall of chip-select. It also changes how many cycles chip-select stays low. Both show up at the ports within the same access. A wrong state after an access shows up as a short or long turnaround gap, or as `req_ready` rising early, or as a missing or duplicated done pulse. These appear within one gap of the access that caused them. A bad width decode or a bad capture point shows up as a wrong read word or a wrong driven byte in that access's completion cycle.

// File: rtl/static_mem_seq.sv
module static_mem_seq #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_we_dly,
  input  logic [3:0]    cfg_oe_dly,
  input  logic [4:0]    cfg_rd_len,
  input  logic [4:0]    cfg_wr_len,
  input  logic [3:0]    cfg_turn,
  input  logic [1:0]    cfg_width,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_done,
  output logic [15:0]   rsp_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_TURN} state_t;

  state_t        state;
  logic [5:0]    cnt;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;

  logic        wide16;
  logic [5:0]  rd_last, wr_last, we_raw, we_start;
  logic [5:0]  turn_last;
  logic        start;

  assign wide16    = (cfg_width != 2'b00);
  assign rd_last   = {1'b0, cfg_rd_len};
  assign wr_last   = {1'b0, cfg_wr_len} + 6'd1;
  assign we_raw    = {2'b00, cfg_we_dly} + 6'd1;
  assign we_start  = (we_raw > wr_last) ? wr_last : we_raw;
  assign turn_last = (cfg_turn == 4'hF) ? 6'd14 : {2'b00, cfg_turn};

  assign req_ready = (state == S_IDLE) || (state == S_TURN && cnt == turn_last);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE, S_TURN: begin
          if (start) begin
            state   <= req_write ? S_WR : S_RD;
            cnt     <= '0;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end else if (state == S_TURN) begin
            if (cnt == turn_last) state <= S_IDLE;
            else cnt <= cnt + 6'd1;
          end
        end
        S_RD: begin
          if (cnt == rd_last) begin
            state     <= S_TURN;
            cnt       <= '0;
            rsp_done  <= 1'b1;
            rsp_rdata <= wide16 ? mem_dq_in : {8'h00, mem_dq_in[7:0]};
          end else cnt <= cnt + 6'd1;
        end
        default: begin
          if (cnt == wr_last) begin
            state    <= S_TURN;
            cnt      <= '0;
            rsp_done <= 1'b1;
          end else cnt <= cnt + 6'd1;
        end
      endcase
    end
  end

  assign mem_cs_n   = !(state == S_RD || state == S_WR);
  assign mem_oe_n   = !(state == S_RD && cnt >= {2'b00, cfg_oe_dly});
  assign mem_we_n   = !(state == S_WR && cnt >= we_start);
  assign mem_dq_oe  = (state == S_WR);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wide16 ? wdata_q : {8'h00, wdata_q[7:0]};

  // R1: strobes idle high whenever chip select is released
  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n));

  a_r3_oe_rises_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> mem_cs_n);

  a_r5_we_rises_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_cs_n);

  a_r7_start_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> $past(req_valid && req_ready));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && $past(!mem_cs_n)));

  a_r11_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

endmodule

// File: tb/static_mem_seq_tb.sv
`timescale 1ns/1ps
module static_mem_seq_tb;
  localparam int AW = 24;

  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_we_dly, cfg_oe_dly, cfg_turn;
  logic [4:0] cfg_rd_len, cfg_wr_len;
  logic [1:0] cfg_width;
  logic req_valid = 0, req_write = 0;
  logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  static_mem_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_dly(cfg_we_dly), .cfg_oe_dly(cfg_oe_dly), .cfg_rd_len(cfg_rd_len),
    .cfg_wr_len(cfg_wr_len), .cfg_turn(cfg_turn), .cfg_width(cfg_width),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  assign mem_dq_in = mem_oe_n ? 16'h0000 : (mem_addr[15:0] ^ 16'h5A3C);

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic [7:0]  len;
    logic [7:0]  first;
    logic [7:0]  gap;
    logic        gapchk;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  int turn_gap = 3;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor
  bit in_acc = 0, seen_any = 0;
  int idx, oe_first, we_first, gapcnt = 1000, gap_seen;
  bit dq_bad;
  logic [15:0] wr_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n) begin
        if (!in_acc) begin
          in_acc = 1; idx = 0; gap_seen = gapcnt;
          oe_first = -1; we_first = -1; dq_bad = 0; wr_seen = mem_dq_out;
        end
        if (!mem_oe_n && oe_first < 0) oe_first = idx;
        if (!mem_we_n && we_first < 0) we_first = idx;
        if (!mem_we_n && !mem_oe_n) check(0, "R11", "oe and we both low", 1, 0);
        if (mem_dq_out !== wr_seen) dq_bad = 1;
        idx++;
      end else begin
        if (in_acc) begin
          exp_t e;
          in_acc = 0;
          gapcnt = 1;
          seen_any = 1;
          if (exp_q.size() == 0) check(0, "R10", "unexpected access", 1, 0);
          else begin
            e = exp_q.pop_front();
            check(rsp_done === 1'b1, "R10", "done in first high cycle", rsp_done, 1);
            check(mem_oe_n && mem_we_n, "R3", "strobes release with cs", {mem_oe_n, mem_we_n}, 3);
            if (e.gapchk)
              check(gap_seen == int'(e.gap), "R7", "back-to-back gap", gap_seen, e.gap);
            if (e.wr) begin
              check(idx == int'(e.len), "R5", "write cs low cycles", idx, e.len);
              check(we_first == int'(e.first), "R4", "we fall offset", we_first, e.first);
              check(!dq_bad && wr_seen == e.data, "R9", "write data on bus", wr_seen, e.data);
            end else begin
              check(idx == int'(e.len), "R3", "read cs low cycles", idx, e.len);
              check(oe_first == (e.first == 8'hFF ? -1 : int'(e.first)), "R2", "oe fall offset", oe_first, e.first);
              check(rsp_rdata == e.data, "R3", "read data", rsp_rdata, e.data);
            end
          end
        end else begin
          gapcnt++;
          if (rsp_done) check(0, "R10", "spurious done", 1, 0);
        end
        if (seen_any && gapcnt <= 40)
          check(req_ready == (gapcnt >= turn_gap), "R7", "ready during gap", req_ready, gapcnt >= turn_gap);
      end
      if (in_acc && mem_dq_oe !== 1'b1 && exp_q.size() > 0 && exp_q[0].wr)
        check(0, "R5", "dq_oe low in write", mem_dq_oe, 1);
    end
  end

  task automatic set_cfg(input int wed, input int oed, input int rdl, input int wrl, input int trn, input int wid);
    cfg_we_dly = 4'(wed); cfg_oe_dly = 4'(oed); cfg_rd_len = 5'(rdl);
    cfg_wr_len = 5'(wrl); cfg_turn = 4'(trn); cfg_width = 2'(wid);
    turn_gap = ((trn == 15) ? 14 : trn) + 1;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input bit gapchk);
    exp_t e;
    int wfirst;
    logic [15:0] mem_word;
    mem_word = a[15:0] ^ 16'h5A3C;
    e.wr = wr; e.gapchk = gapchk; e.gap = 8'(turn_gap);
    if (wr) begin
      e.len = 8'(cfg_wr_len + 2);
      wfirst = cfg_we_dly + 1;
      if (wfirst > cfg_wr_len + 1) wfirst = cfg_wr_len + 1;
      e.first = 8'(wfirst);
      e.data = (cfg_width == 2'b00) ? {8'h00, d[7:0]} : d;
    end else begin
      e.len = 8'(cfg_rd_len + 1);
      if (cfg_oe_dly <= cfg_rd_len) begin
        e.first = 8'(cfg_oe_dly);
        e.data = (cfg_width == 2'b00) ? {8'h00, mem_word[7:0]} : mem_word;
      end else begin
        e.first = 8'hFF;
        e.data = 16'h0000;
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_cfg(0, 0, 10, 7, 2, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1", "idle strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(rsp_done == 0, "R1", "no done after reset", rsp_done, 0);
    repeat (3) @(negedge clk);
    check(mem_cs_n && !rsp_done, "R1", "still idle", mem_cs_n, 1);

    issue(0, 24'h000123, 16'h0, 0); settle();
    issue(1, 24'h000456, 16'hBEEF, 0); settle();

    set_cfg(0, 3, 5, 7, 2, 1); issue(0, 24'h001111, 16'h0, 0); settle();      // R2
    set_cfg(0, 0, 0, 7, 2, 1); issue(0, 24'h002222, 16'h0, 0); settle();      // R3 single cycle
    set_cfg(0, 9, 4, 7, 2, 1); issue(0, 24'h003333, 16'h0, 0); settle();      // R2 oe never
    set_cfg(2, 0, 4, 4, 2, 1); issue(1, 24'h004444, 16'h1234, 0); settle();   // R4
    set_cfg(0, 0, 4, 0, 2, 1); issue(1, 24'h005555, 16'h5678, 0); settle();   // R5 min
    set_cfg(9, 0, 4, 3, 2, 1); issue(1, 24'h006666, 16'h9ABC, 0); settle();   // R6 clamp
    set_cfg(15, 0, 4, 0, 2, 1); issue(1, 24'h006677, 16'h0F0F, 0); settle();  // R6 clamp

    set_cfg(0, 1, 3, 2, 2, 0);                                                 // R9 8-bit
    issue(0, 24'h0077A5, 16'h0, 0); settle();
    issue(1, 24'h007700, 16'hC3D4, 0); settle();
    set_cfg(0, 1, 3, 2, 2, 2); issue(0, 24'h0088B6, 16'h0, 0); settle();      // R9 reserved
    set_cfg(0, 1, 3, 2, 2, 3); issue(1, 24'h008800, 16'hE5F6, 0); settle();   // R9 reserved

    set_cfg(0, 0, 2, 1, 0, 1);                                                 // R7 turn 0
    issue(0, 24'h000A01, 16'h0, 0); issue(0, 24'h000A02, 16'h0, 1); settle();
    set_cfg(1, 0, 2, 3, 5, 1);                                                 // R7 turn 5
    issue(1, 24'h000B01, 16'h1111, 0); issue(0, 24'h000B02, 16'h0, 1);
    issue(1, 24'h000B03, 16'h2222, 1); settle();
    set_cfg(0, 0, 1, 1, 15, 1);                                                // R8 turn 15
    issue(0, 24'h000C01, 16'h0, 0); issue(1, 24'h000C02, 16'h3333, 1); settle();
    set_cfg(0, 0, 1, 1, 14, 1);                                                // R8 reference
    issue(0, 24'h000C03, 16'h0, 0); issue(0, 24'h000C04, 16'h0, 1); settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule